// File: doc/BRIEF.md
# Interrupt Entry and Vectoring Sequencer

This block sits next to a simple in-order core and takes over whenever control must pass into an exception or interrupt handler. At an instruction boundary it looks at three kinds of request: an exception raised inside the core, a non-maskable hardware request and a maskable hardware request. It selects one of them and settles on an 8-bit vector. It then saves the working flags, the current code segment and the correct return address through a word-wide stack-write port. For a maskable request it runs a two-cycle acknowledge handshake to obtain the vector. It reads the handler entry from a vector table through a memory-read port and finally hands the core a new code segment, a new instruction offset and the flags the handler starts with.

Table entries take one of two formats. The compact format uses 4-byte entries and the extended format uses 8-byte entries. The core picks the format with a mode input. A return-from-handler request pops the three saved words in reverse order and hands them back to the core, so that the interrupted program resumes.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `redirect`, `iack`, `stk_push`, `stk_pop` and `mem_rd` are all 0 until a request is accepted.
- R2: Requests are sampled only in the idle state on a cycle with `boundary` high. When several are present, an exception wins over a non-maskable request, which wins over a maskable request. A non-maskable request that loses stays pending for a later boundary.
- R3: A maskable request is accepted only when `intr_req` is 1 and bit 9 of `flags_in` (the interrupt-enable flag) is 1. If that bit is 0, nothing starts.
- R4: A non-maskable request (a one-cycle pulse on `nmi_req`, remembered until taken) always uses vector 2. After one is accepted, further non-maskable requests stay pending and are not taken until a return sequence has completed.
- R5: The return address pushed is `cur_pc` for a fault (`exc_cls`=0) and for an abort (`exc_cls`=2). It is `next_pc` for a trap (`exc_cls`=1) and for both hardware requests. On an abort entry, `nonrestart` is 1 in the cycle of `redirect`.
- R6: On the three cycles after acceptance, `stk_push` is 1 and `stk_wdata` carries, in this order, the zero-extended flags, the zero-extended code segment and the return address.
- R7: For a maskable request, `iack` is high for exactly two cycles directly after the pushes. The vector is taken from `iack_vec` at the end of the second cycle; the value present in the first cycle is ignored.
- R8: The table is read after the pushes (and after the acknowledge). `mem_rdata` is expected one cycle after `mem_rd`. With `mode_prot`=0 there is one read at vector×4: bits 15:0 give the offset and bits 31:16 the segment. With `mode_prot`=1 there are reads at vector×8 and then vector×8+4: the first word gives the offset low half (15:0) and the segment (31:16), and the second word's bits 31:16 give the offset high half. The mode is captured at acceptance.
- R9: An entry ends with a one-cycle `redirect`, with `resume`=0. In that cycle `tgt_cs` and `tgt_ip` come from the table entry, `flags_wdata` equals the captured flags with bit 9 cleared, and `vec_out` is the chosen vector.
- R10: When `iret_req` is 1 in the idle state, a return is performed instead of any entry that cycle. `stk_pop` is high for three cycles, and `stk_rdata` is expected one cycle after each pop. A one-cycle `redirect` with `resume`=1 then restores `tgt_ip`, `tgt_cs` and `flags_wdata` from the popped return address, segment and flags.
- R11: While `busy` is 1, `boundary`, `exc_req` and `iret_req` are ignored. No second sequence starts until the current one has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | Core is between instructions this cycle |
| exc_req | input | 1 | Internal exception request |
| exc_vec | input | 8 | Vector of the internal exception |
| exc_cls | input | 2 | Exception class: 0 fault, 1 trap, 2 abort |
| nmi_req | input | 1 | Non-maskable request pulse |
| intr_req | input | 1 | Maskable request level |
| iret_req | input | 1 | Return-from-handler request |
| mode_prot | input | 1 | 1 selects 8-byte table entries |
| cur_pc | input | DW | Address of the current instruction including prefixes |
| next_pc | input | DW | Address of the following instruction |
| cur_cs | input | SEG_W | Current code segment |
| flags_in | input | FLG_W | Working flags |
| iack | output | 1 | Acknowledge strobe for the maskable vector |
| iack_vec | input | 8 | Vector bus driven by the interrupt source |
| stk_push | output | 1 | Stack write strobe |
| stk_wdata | output | DW | Stack write word |
| stk_pop | output | 1 | Stack read strobe |
| stk_rdata | input | DW | Stack read word, one cycle after `stk_pop` |
| mem_rd | output | 1 | Table read strobe |
| mem_addr | output | DW | Table read address |
| mem_rdata | input | DW | Table read word, one cycle after `mem_rd` |
| busy | output | 1 | A sequence is in progress |
| redirect | output | 1 | One-cycle transfer of control to the core |
| resume | output | 1 | The redirect ends a return sequence |
| nonrestart | output | 1 | The entry is an abort with no precise return address |
| tgt_cs | output | SEG_W | New code segment |
| tgt_ip | output | DW | New instruction offset |
| flags_wdata | output | FLG_W | Flags for the core to load on redirect |
| vec_out | output | 8 | Vector of the last entry |

## Verification
Two functions can fall on the same idle cycle. A return request can coincide with a maskable request at a boundary, and all three entry sources can coincide at one boundary. The bench raises `iret_req`, `boundary` and `intr_req` together and requires that the observed redirect is a resume carrying the popped frame, with no pushes and no acknowledge. It then raises an exception, a non-maskable pulse and a maskable request in one cycle. It requires the exception's frame first, then the non-maskable entry with vector 2 after the return, then the acknowledged maskable entry, all matched against queued expectations in order.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXC  = 2'd1,
    SRC_NMI  = 2'd2,
    SRC_INT  = 2'd3
  } src_e;

  localparam logic [1:0] CLS_FAULT = 2'd0;
  localparam logic [1:0] CLS_TRAP  = 2'd1;
  localparam logic [1:0] CLS_ABORT = 2'd2;

  localparam logic [7:0] NMI_VECTOR = 8'd2;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_PSH_F  = 4'd1,
    ST_PSH_CS = 4'd2,
    ST_PSH_PC = 4'd3,
    ST_ACK1   = 4'd4,
    ST_ACK2   = 4'd5,
    ST_RD0    = 4'd6,
    ST_RD1    = 4'd7,
    ST_WLAST  = 4'd8,
    ST_FIN    = 4'd9,
    ST_POP_PC = 4'd10,
    ST_POP_CS = 4'd11,
    ST_POP_F  = 4'd12,
    ST_RWAIT  = 4'd13,
    ST_RFIN   = 4'd14
  } seq_st_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_src_arb.sv
module irq_src_arb
  import irq_seq_pkg::*;
(
  input  logic boundary,
  input  logic exc_req,
  input  logic nmi_live,
  input  logic nmi_block,
  input  logic intr_req,
  input  logic int_en,
  output src_e grant
);
  always_comb begin
    grant = SRC_NONE;
    if (boundary) begin
      if (exc_req)                      grant = SRC_EXC;
      else if (nmi_live && !nmi_block)  grant = SRC_NMI;
      else if (intr_req && int_en)      grant = SRC_INT;
    end
  end
endmodule

// File: rtl/irq_ret_sel.sv
module irq_ret_sel
  import irq_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  src_e          src,
  input  logic [1:0]    cls,
  input  logic [DW-1:0] cur_pc,
  input  logic [DW-1:0] next_pc,
  output logic [DW-1:0] ret_pc,
  output logic          is_abort
);
  logic restart_here;

  always_comb begin
    restart_here = 1'b0;
    is_abort     = 1'b0;
    if (src == SRC_EXC) begin
      restart_here = (cls != CLS_TRAP);
      is_abort     = (cls == CLS_ABORT);
    end
    ret_pc = restart_here ? cur_pc : next_pc;
  end
endmodule

// File: rtl/irq_tbl_addr.sv
module irq_tbl_addr #(
  parameter int          DW       = 32,
  parameter int unsigned TBL_BASE = 0
) (
  input  logic [7:0]    vec,
  input  logic          prot,
  input  logic          second,
  output logic [DW-1:0] addr
);
  localparam int SH_COMPACT  = 2;
  localparam int SH_EXTENDED = 3;
  localparam logic [DW-1:0] BASE     = DW'(TBL_BASE);
  localparam logic [DW-1:0] WORD_OFS = DW'(4);

  logic [DW-1:0] vec_ext;
  logic [DW-1:0] entry_ofs;

  assign vec_ext   = DW'(vec);
  assign entry_ofs = prot ? (vec_ext << SH_EXTENDED) : (vec_ext << SH_COMPACT);
  assign addr      = BASE + entry_ofs + (second ? WORD_OFS : '0);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          SEG_W    = 16,
  parameter int          FLG_W    = 16,
  parameter int          IE_POS   = 9,
  parameter int unsigned TBL_BASE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             exc_req,
  input  logic [7:0]       exc_vec,
  input  logic [1:0]       exc_cls,
  input  logic             nmi_req,
  input  logic             intr_req,
  input  logic             iret_req,
  input  logic             mode_prot,
  input  logic [DW-1:0]    cur_pc,
  input  logic [DW-1:0]    next_pc,
  input  logic [SEG_W-1:0] cur_cs,
  input  logic [FLG_W-1:0] flags_in,
  output logic             iack,
  input  logic [7:0]       iack_vec,
  output logic             stk_push,
  output logic [DW-1:0]    stk_wdata,
  output logic             stk_pop,
  input  logic [DW-1:0]    stk_rdata,
  output logic             mem_rd,
  output logic [DW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic             redirect,
  output logic             resume,
  output logic             nonrestart,
  output logic [SEG_W-1:0] tgt_cs,
  output logic [DW-1:0]    tgt_ip,
  output logic [FLG_W-1:0] flags_wdata,
  output logic [7:0]       vec_out
);
  localparam int HW = DW / 2;
  localparam logic [FLG_W-1:0] IE_MASK = FLG_W'(1) << IE_POS;

  logic rst_int_n;

  seq_st_e          st_q, st_n;
  src_e             src_q, src_n, grant;
  logic [7:0]       vec_q, vec_n;
  logic             abort_q, abort_n;
  logic             prot_q, prot_n;
  logic [DW-1:0]    ret_q, ret_n;
  logic [SEG_W-1:0] cs_q, cs_n;
  logic [FLG_W-1:0] flg_q, flg_n;
  logic [DW-1:0]    w0_q, w0_n;
  logic [DW-1:0]    tip_q, tip_n;
  logic [SEG_W-1:0] tcs_q, tcs_n;
  logic             nmi_pend_q, nmi_pend_n;
  logic             nmi_blk_q, nmi_blk_n;

  logic             idle;
  logic             nmi_live;
  logic [DW-1:0]    sel_ret;
  logic             sel_abort;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign idle     = (st_q == ST_IDLE);
  assign nmi_live = nmi_pend_q | nmi_req;

  irq_src_arb u_arb (
    .boundary  (boundary && idle && !iret_req),
    .exc_req   (exc_req),
    .nmi_live  (nmi_live),
    .nmi_block (nmi_blk_q),
    .intr_req  (intr_req),
    .int_en    (flags_in[IE_POS]),
    .grant     (grant)
  );

  irq_ret_sel #(.DW(DW)) u_ret (
    .src      (grant),
    .cls      (exc_cls),
    .cur_pc   (cur_pc),
    .next_pc  (next_pc),
    .ret_pc   (sel_ret),
    .is_abort (sel_abort)
  );

  irq_tbl_addr #(.DW(DW), .TBL_BASE(TBL_BASE)) u_tbl (
    .vec    (vec_q),
    .prot   (prot_q),
    .second (st_q == ST_RD1),
    .addr   (mem_addr)
  );

  // next-state process
  always_comb begin
    st_n       = st_q;
    src_n      = src_q;
    vec_n      = vec_q;
    abort_n    = abort_q;
    prot_n     = prot_q;
    ret_n      = ret_q;
    cs_n       = cs_q;
    flg_n      = flg_q;
    w0_n       = w0_q;
    tip_n      = tip_q;
    tcs_n      = tcs_q;
    nmi_pend_n = nmi_live && !(grant == SRC_NMI);
    nmi_blk_n  = nmi_blk_q;

    unique case (st_q)
      ST_IDLE: begin
        if (iret_req) begin
          st_n = ST_POP_PC;
        end else if (grant != SRC_NONE) begin
          st_n    = ST_PSH_F;
          src_n   = grant;
          abort_n = sel_abort;
          prot_n  = mode_prot;
          ret_n   = sel_ret;
          cs_n    = cur_cs;
          flg_n   = flags_in;
          unique case (grant)
            SRC_EXC: vec_n = exc_vec;
            SRC_NMI: vec_n = NMI_VECTOR;
            default: vec_n = 8'd0;
          endcase
          if (grant == SRC_NMI) nmi_blk_n = 1'b1;
        end
      end
      ST_PSH_F:  st_n = ST_PSH_CS;
      ST_PSH_CS: st_n = ST_PSH_PC;
      ST_PSH_PC: st_n = (src_q == SRC_INT) ? ST_ACK1 : ST_RD0;
      ST_ACK1:   st_n = ST_ACK2;
      ST_ACK2: begin
        st_n  = ST_RD0;
        vec_n = iack_vec;
      end
      ST_RD0:    st_n = prot_q ? ST_RD1 : ST_WLAST;
      ST_RD1: begin
        st_n = ST_WLAST;
        w0_n = mem_rdata;
      end
      ST_WLAST: begin
        st_n = ST_FIN;
        if (prot_q) begin
          tip_n = {mem_rdata[DW-1:HW], w0_q[HW-1:0]};
          tcs_n = w0_q[HW +: SEG_W];
        end else begin
          tip_n = DW'(mem_rdata[HW-1:0]);
          tcs_n = mem_rdata[HW +: SEG_W];
        end
      end
      ST_FIN:    st_n = ST_IDLE;
      ST_POP_PC: st_n = ST_POP_CS;
      ST_POP_CS: begin
        st_n  = ST_POP_F;
        tip_n = stk_rdata;
      end
      ST_POP_F: begin
        st_n  = ST_RWAIT;
        tcs_n = stk_rdata[SEG_W-1:0];
      end
      ST_RWAIT: begin
        st_n  = ST_RFIN;
        flg_n = stk_rdata[FLG_W-1:0];
      end
      ST_RFIN: begin
        st_n      = ST_IDLE;
        nmi_blk_n = 1'b0;
      end
      default:   st_n = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q       <= ST_IDLE;
      src_q      <= SRC_NONE;
      vec_q      <= 8'd0;
      abort_q    <= 1'b0;
      prot_q     <= 1'b0;
      ret_q      <= '0;
      cs_q       <= '0;
      flg_q      <= '0;
      w0_q       <= '0;
      tip_q      <= '0;
      tcs_q      <= '0;
      nmi_pend_q <= 1'b0;
      nmi_blk_q  <= 1'b0;
    end else begin
      st_q       <= st_n;
      src_q      <= src_n;
      vec_q      <= vec_n;
      abort_q    <= abort_n;
      prot_q     <= prot_n;
      ret_q      <= ret_n;
      cs_q       <= cs_n;
      flg_q      <= flg_n;
      w0_q       <= w0_n;
      tip_q      <= tip_n;
      tcs_q      <= tcs_n;
      nmi_pend_q <= nmi_pend_n;
      nmi_blk_q  <= nmi_blk_n;
    end
  end

  // outputs, all decoded from registered state
  always_comb begin
    stk_push = 1'b0;
    stk_wdata = '0;
    unique case (st_q)
      ST_PSH_F: begin
        stk_push  = 1'b1;
        stk_wdata = DW'(flg_q);
      end
      ST_PSH_CS: begin
        stk_push  = 1'b1;
        stk_wdata = DW'(cs_q);
      end
      ST_PSH_PC: begin
        stk_push  = 1'b1;
        stk_wdata = ret_q;
      end
      default: ;
    endcase
  end

  assign stk_pop     = (st_q == ST_POP_PC) || (st_q == ST_POP_CS) || (st_q == ST_POP_F);
  assign iack        = (st_q == ST_ACK1) || (st_q == ST_ACK2);
  assign mem_rd      = (st_q == ST_RD0) || (st_q == ST_RD1);
  assign busy        = !idle;
  assign redirect    = (st_q == ST_FIN) || (st_q == ST_RFIN);
  assign resume      = (st_q == ST_RFIN);
  assign nonrestart  = (st_q == ST_FIN) && abort_q;
  assign tgt_cs      = tcs_q;
  assign tgt_ip      = tip_q;
  assign flags_wdata = (st_q == ST_RFIN) ? flg_q : (flg_q & ~IE_MASK);
  assign vec_out     = vec_q;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       iack,
  input logic       stk_push,
  input logic       stk_pop,
  input logic       mem_rd,
  input logic [1:0] addr_lo,
  input logic       redirect,
  input logic       resume,
  input logic       nonrestart,
  input logic       ie_out
);
  // R7
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack) |=> iack);

  // R7
  ack_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && $past(iack)) |=> !iack);

  // R6
  push_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_push |-> !(mem_rd || stk_pop || iack));

  // R8
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (addr_lo == 2'b00));

  // R9
  redir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  // R9
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !resume) |-> !ie_out);

  // R5
  abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nonrestart |-> (redirect && !resume));
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iack       (iack),
  .stk_push   (stk_push),
  .stk_pop    (stk_pop),
  .mem_rd     (mem_rd),
  .addr_lo    (mem_addr[1:0]),
  .redirect   (redirect),
  .resume     (resume),
  .nonrestart (nonrestart),
  .ie_out     (flags_wdata[IE_POS])
);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        boundary, exc_req, nmi_req, intr_req, iret_req, mode_prot;
  logic [7:0]  exc_vec;
  logic [1:0]  exc_cls;
  logic [31:0] cur_pc, next_pc;
  logic [15:0] cur_cs, flags_in;
  logic        iack;
  logic [7:0]  iack_vec;
  logic        stk_push, stk_pop, mem_rd;
  logic [31:0] stk_wdata, stk_rdata, mem_addr, mem_rdata;
  logic        busy, redirect, resume, nonrestart;
  logic [15:0] tgt_cs, flags_wdata;
  logic [31:0] tgt_ip;
  logic [7:0]  vec_out;

  irq_entry_seq uut (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  localparam logic [7:0] ACK_GOOD = 8'h40;
  localparam logic [7:0] ACK_JUNK = 8'hEE;

  typedef struct packed {
    logic [15:0] cs;
    logic [31:0] ip;
    logic [15:0] fl;
    logic        nr;
    logic        rs;
    logic [7:0]  vec;
  } redir_t;

  typedef struct packed {
    logic [15:0] fl;
    logic [15:0] cs;
    logic [31:0] ret;
  } frame_t;

  logic [31:0] e_push_q[$];  string e_push_t[$];
  logic [31:0] e_addr_q[$];  string e_addr_t[$];
  redir_t      e_red_q[$];   string e_red_t[$];
  frame_t      frames[$];
  logic [31:0] stk_model[$];

  function automatic logic [31:0] tbl_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A00, a[15:0] + 16'h0100};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory and stack models: read data one cycle after the strobe
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= tbl_word(mem_addr);
    if (stk_push) stk_model.push_back(stk_wdata);
    if (stk_pop) stk_rdata <= (stk_model.size() != 0) ? stk_model.pop_back() : 32'h0;
  end

  // acknowledge source: junk in the first cycle, valid vector in the second
  bit ack_prev = 0;
  always @(posedge clk) begin
    #1;
    iack_vec = (iack && ack_prev) ? ACK_GOOD : ACK_JUNK;
    ack_prev = iack;
  end

  // monitor: compares design activity against queued expectations
  int ack_run = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stk_push) begin
        if (e_push_q.size() == 0) check("R11", 1, 0, "unexpected stack push");
        else check({e_push_t.pop_front(), "/R6"}, stk_wdata, e_push_q.pop_front(), "pushed word");
      end
      if (mem_rd) begin
        if (e_addr_q.size() == 0) check("R11", 1, 0, "unexpected table read");
        else check({e_addr_t.pop_front(), "/R8"}, mem_addr, e_addr_q.pop_front(), "table address");
      end
      if (iack) ack_run++;
      else if (ack_run != 0) begin
        check("R7", ack_run, 2, "acknowledge cycles");
        ack_run = 0;
      end
      if (redirect) begin
        if (e_red_q.size() == 0) check("R11", 1, 0, "unexpected redirect");
        else begin
          redir_t e;
          string  t;
          e = e_red_q.pop_front();
          t = e_red_t.pop_front();
          check({t, "/R9"}, tgt_cs, e.cs, "target segment");
          check({t, "/R9"}, tgt_ip, e.ip, "target offset");
          check({t, "/R9"}, flags_wdata, e.fl, "flags");
          check({t, "/R5"}, nonrestart, e.nr, "nonrestart");
          check({t, "/R10"}, resume, e.rs, "resume");
          if (!e.rs) check({t, "/R4"}, vec_out, e.vec, "vector");
        end
      end
    end
  end

  task automatic exp_entry(input string tag, input logic [31:0] ret, input logic [7:0] vec, input logic nr);
    logic [31:0] base, w0, w1;
    redir_t r;
    frame_t f;
    e_push_q.push_back({16'h0, flags_in}); e_push_t.push_back(tag);
    e_push_q.push_back({16'h0, cur_cs});   e_push_t.push_back(tag);
    e_push_q.push_back(ret);               e_push_t.push_back({tag, "/R5"});
    base = mode_prot ? ({24'h0, vec} << 3) : ({24'h0, vec} << 2);
    w0 = tbl_word(base);
    w1 = tbl_word(base + 32'd4);
    e_addr_q.push_back(base); e_addr_t.push_back(tag);
    if (mode_prot) begin e_addr_q.push_back(base + 32'd4); e_addr_t.push_back(tag); end
    r.cs  = w0[31:16];
    r.ip  = mode_prot ? {w1[31:16], w0[15:0]} : {16'h0, w0[15:0]};
    r.fl  = flags_in & ~16'h0200;
    r.nr  = nr;
    r.rs  = 1'b0;
    r.vec = vec;
    e_red_q.push_back(r); e_red_t.push_back(tag);
    f.fl = flags_in; f.cs = cur_cs; f.ret = ret;
    frames.push_back(f);
  endtask

  task automatic exp_return(input string tag);
    frame_t f;
    redir_t r;
    f = frames.pop_back();
    r.cs = f.cs; r.ip = f.ret; r.fl = f.fl; r.nr = 1'b0; r.rs = 1'b1; r.vec = 8'h0;
    e_red_q.push_back(r); e_red_t.push_back(tag);
  endtask

  task automatic cyc(input logic b, input logic ex, input logic [7:0] v,
                     input logic [1:0] c, input logic n, input logic ir);
    @(negedge clk);
    boundary = b; exc_req = ex; exc_vec = v; exc_cls = c; nmi_req = n; iret_req = ir;
    @(negedge clk);
    boundary = 0; exc_req = 0; nmi_req = 0; iret_req = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_return(input string tag);
    exp_return(tag);
    cyc(0, 0, 8'h0, 2'd0, 0, 1);
    wait_idle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL R11 watchdog: actual busy %0b expected idle completion", busy);
    finish_run();
  end

  initial begin
    rst_n = 0; boundary = 0; exc_req = 0; nmi_req = 0; intr_req = 0; iret_req = 0;
    mode_prot = 0; exc_vec = 0; exc_cls = 0; cur_pc = 32'h1000; next_pc = 32'h1004;
    cur_cs = 16'h0700; flags_in = 16'h0246; stk_rdata = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    check("R1", {busy, redirect, iack, stk_push, stk_pop, mem_rd}, 0, "outputs in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", {busy, redirect, iack, stk_push, stk_pop, mem_rd}, 0, "outputs after reset");

    // R4 non-maskable entry, compact table, then R10 return
    exp_entry("R4", next_pc, 8'd2, 0);
    cyc(1, 0, 8'h0, 2'd0, 1, 0);
    wait_idle();
    do_return("R10");

    // R5 fault, extended table: restart address
    mode_prot = 1; cur_pc = 32'h0002_3450; next_pc = 32'h0002_3456;
    exp_entry("R5", cur_pc, 8'd14, 0);
    cyc(1, 1, 8'd14, 2'd0, 0, 0);
    wait_idle();
    do_return("R10");

    // R5 trap, compact table: following address
    mode_prot = 0; cur_cs = 16'h1234;
    exp_entry("R5", next_pc, 8'd3, 0);
    cyc(1, 1, 8'd3, 2'd1, 0, 0);
    wait_idle();
    do_return("R10");

    // R5 abort, extended table: nonrestart flagged
    mode_prot = 1;
    exp_entry("R5", cur_pc, 8'd8, 1);
    cyc(1, 1, 8'd8, 2'd2, 0, 0);
    wait_idle();
    do_return("R10");

    // R3 maskable with enable flag clear: nothing starts
    mode_prot = 0; flags_in = 16'h0046; intr_req = 1;
    cyc(1, 0, 8'h0, 2'd0, 0, 0);
    check("R3", busy, 0, "maskable masked");
    @(negedge clk);
    check("R3", {stk_push, iack}, 0, "no activity while masked");
    // R7 maskable with flag set: acknowledged vector
    flags_in = 16'h0246;
    exp_entry("R7", next_pc, ACK_GOOD, 0);
    cyc(1, 0, 8'h0, 2'd0, 0, 0);
    intr_req = 0;
    wait_idle();
    do_return("R10");

    // R2 exception, NMI pulse and maskable in one cycle
    intr_req = 1;
    exp_entry("R2", next_pc, 8'd5, 0);
    cyc(1, 1, 8'd5, 2'd1, 1, 0);
    wait_idle();
    do_return("R2");
    exp_entry("R2", next_pc, 8'd2, 0);
    cyc(1, 0, 8'h0, 2'd0, 0, 0);
    wait_idle();
    do_return("R2");
    exp_entry("R2", next_pc, ACK_GOOD, 0);
    cyc(1, 0, 8'h0, 2'd0, 0, 0);
    intr_req = 0;
    wait_idle();
    do_return("R2");

    // R4 second NMI blocked until the return completes
    exp_entry("R4", next_pc, 8'd2, 0);
    cyc(1, 0, 8'h0, 2'd0, 1, 0);
    wait_idle();
    cyc(1, 0, 8'h0, 2'd0, 1, 0);
    check("R4", busy, 0, "nested NMI blocked");
    do_return("R4");
    exp_entry("R4", next_pc, 8'd2, 0);
    cyc(1, 0, 8'h0, 2'd0, 0, 0);
    wait_idle();
    do_return("R4");

    // R11 requests while busy are ignored
    exp_entry("R11", next_pc, 8'd2, 0);
    cyc(1, 0, 8'h0, 2'd0, 1, 0);
    cyc(1, 1, 8'd9, 2'd0, 0, 1);
    wait_idle();
    do_return("R11");

    // R10 return and maskable request at the same boundary
    exp_entry("R10", next_pc, 8'd7, 0);
    cyc(1, 1, 8'd7, 2'd1, 0, 0);
    wait_idle();
    intr_req = 1;
    exp_return("R10");
    cyc(1, 0, 8'h0, 2'd0, 0, 1);
    intr_req = 0;
    wait_idle();

    repeat (3) @(negedge clk);
    check("R11", e_push_q.size() + e_addr_q.size() + e_red_q.size(), 0, "expectations left");
    check("R10", stk_model.size(), 0, "stack depth at end");
    finish_run();
  end
endmodule